// File: doc/BRIEF.md
# Inbound Doorbell Queue

This block takes doorbell events arriving from the link side over a valid/ready handshake. Each event carries a 16-bit target ID, a 16-bit source ID and a 16-bit info field. Every good event is stored as one 8-byte record in a circular queue in internal memory. The queue has a power-of-two number of slots, 512 by default, which gives a 4096-byte ring. Software sees the queue through a small word-addressed register bus. It reads the record at the dequeue pointer as two 32-bit words. It then releases that record by writing a one-shot pop bit in the mode register.

Both pointers read back as byte addresses, made of a ring base followed by an offset. The low bits of each pointer are the byte offset of its slot inside the ring. Software loads both pointers with the ring base while the unit is disabled. A set bit in the sticky status register raises the interrupt. Those bits report a non-empty queue, a full queue and a reception error. Writing a one clears a bit. The non-empty bit and the full bit set again if their condition still holds after the clear.

Top module: `doorbell_inbound_queue`

## Requirements
- R1: After reset the mode, status and both pointer registers read 0, and `db_ready` and `irq` are low.
- R2: `db_ready` is high only while the enable bit (mode bit 0) is set and the queue is not full. While the unit is disabled, no event is taken and the enqueue pointer does not move.
- R3: An event accepted with `db_err` low is stored in the slot at the enqueue pointer. The enqueue pointer then advances by 8 bytes and wraps to the ring base after the last slot, the ring being 8 × 2^DEPTH_LOG2 bytes.
- R4: The record at the dequeue pointer reads at register 4 as {16'h0000 pad, target ID} and at register 5 as {source ID, info}. This gives halfword order pad, target, source, info.
- R5: A write to the mode register (register 0) with bit 1 set pops one record when the queue is not empty. The dequeue pointer then advances by 8 bytes with the same wrap. Mode bit 1 always reads back as 0.
- R6: A pop written while the queue is empty is ignored, and the dequeue pointer stays where it is.
- R7: Status bit 0 (register 1) sets whenever the queue is not empty. It clears when a one is written to it. If the queue is still not empty, it sets again on the next cycle. If the queue is empty, it stays clear.
- R8: When the queue holds 2^DEPTH_LOG2 records, `db_ready` is low and status bit 4 sets. No event is taken, the enqueue pointer holds, and the oldest record is not overwritten.
- R9: An event accepted with `db_err` high is dropped without being stored or moving the enqueue pointer, and status bit 7 sets. A new error wins over a clear written in the same cycle.
- R10: `irq` is the OR of status bits 0, 4 and 7. Writing 0x91 to the status register clears all three.
- R11: The dequeue pointer register (register 2) and the enqueue pointer register (register 3) can be written only while the unit is disabled. A dequeue-pointer write sets the shared ring base from the bits above the ring offset. Each write loads its own slot from the offset bits. Writes made while the unit is enabled are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| db_valid | input | 1 | Link-side doorbell event valid |
| db_ready | output | 1 | Queue can take an event this cycle |
| db_target | input | 16 | Target ID of the event |
| db_source | input | 16 | Source ID of the event |
| db_info | input | 16 | Info field of the event |
| db_err | input | 1 | Event was received with an error |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt, OR of the status bits |

## Verification
The bench builds the queue with DEPTH_LOG2 = 3, which gives eight slots and a 64-byte ring. With that size, a handful of events fills the queue. This brings the full condition, the refused events and the check that no record is overwritten within reach, and it lets both pointers wrap past the ring end in one short run. The ring base is placed above the offset field, so the bench can see whether pointer readback keeps the base bits and the offset apart.

// File: rtl/dbq_pkg.sv
package dbq_pkg;

    localparam int REC_BYTES_LOG2 = 3;

    localparam int MODE_EN_BIT  = 0;
    localparam int MODE_POP_BIT = 1;

    localparam int ST_NE_BIT  = 0;
    localparam int ST_QF_BIT  = 4;
    localparam int ST_ERR_BIT = 7;

    typedef enum logic [2:0] {
        RA_MODE   = 3'd0,
        RA_STATUS = 3'd1,
        RA_DEQ    = 3'd2,
        RA_ENQ    = 3'd3,
        RA_REC_HI = 3'd4,
        RA_REC_LO = 3'd5
    } dbq_reg_e;

    typedef struct packed {
        logic [15:0] target;
        logic [15:0] source;
        logic [15:0] info;
    } dbq_rec_t;

    // Upper word holds the zero pad halfword then the target ID.
    function automatic logic [31:0] rec_word(input dbq_rec_t r, input logic upper);
        return upper ? {16'h0000, r.target} : {r.source, r.info};
    endfunction

endpackage

// File: rtl/dbq_ring_ptrs.sv
module dbq_ring_ptrs #(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop_req,
    input  logic             load_deq,
    input  logic             load_enq,
    input  logic [IDX_W-1:0] load_idx,
    output logic [IDX_W-1:0] deq_idx,
    output logic [IDX_W-1:0] enq_idx,
    output logic             empty,
    output logic             full
);
    logic [IDX_W:0] deq_q, enq_q;
    logic           pop, any_load;

    assign deq_idx  = deq_q[IDX_W-1:0];
    assign enq_idx  = enq_q[IDX_W-1:0];
    assign empty    = (deq_q == enq_q);
    assign full     = (deq_idx == enq_idx) && (deq_q[IDX_W] != enq_q[IDX_W]);
    assign pop      = pop_req && !empty;
    assign any_load = load_deq || load_enq;

    always_ff @(posedge clk) begin
        if (rst) begin
            deq_q <= '0;
            enq_q <= '0;
        end else if (any_load) begin
            deq_q <= {1'b0, load_deq ? load_idx : deq_idx};
            enq_q <= {1'b0, load_enq ? load_idx : enq_idx};
        end else begin
            if (pop)  deq_q <= deq_q + 1'b1;
            if (push) enq_q <= enq_q + 1'b1;
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_req && empty && !any_load) |=> $stable(deq_q));

    // R3
    fill_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop_req && !any_load) |=> !empty);

endmodule

// File: rtl/dbq_rec_ram.sv
module dbq_rec_ram
    import dbq_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  dbq_rec_t         wr_rec,
    input  logic [IDX_W-1:0] rd_idx,
    output dbq_rec_t         rd_rec
);
    localparam int SLOTS = 1 << IDX_W;

    dbq_rec_t mem [SLOTS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_rec;
    end

    assign rd_rec = mem[rd_idx];

endmodule

// File: rtl/dbq_status.sv
module dbq_status
    import dbq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_wr,
    input  logic [7:0] clr_mask,
    input  logic       empty,
    input  logic       full,
    input  logic       err_evt,
    output logic [7:0] status,
    output logic       irq
);
    logic st_ne, st_qf, st_err;
    logic clr_ne, clr_qf, clr_err;

    assign clr_ne  = clr_wr && clr_mask[ST_NE_BIT];
    assign clr_qf  = clr_wr && clr_mask[ST_QF_BIT];
    assign clr_err = clr_wr && clr_mask[ST_ERR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_ne  <= 1'b0;
            st_qf  <= 1'b0;
            st_err <= 1'b0;
        end else begin
            if (clr_ne)      st_ne <= 1'b0;
            else if (!empty) st_ne <= 1'b1;
            if (clr_qf)      st_qf <= 1'b0;
            else if (full)   st_qf <= 1'b1;
            if (err_evt)      st_err <= 1'b1;
            else if (clr_err) st_err <= 1'b0;
        end
    end

    always_comb begin
        status             = '0;
        status[ST_NE_BIT]  = st_ne;
        status[ST_QF_BIT]  = st_qf;
        status[ST_ERR_BIT] = st_err;
    end

    assign irq = st_ne || st_qf || st_err;

    // R7
    ne_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_ne && !clr_ne) |=> st_ne);

    // R7
    ne_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (!empty && !clr_ne) |=> st_ne);

    // R8
    full_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !clr_qf) |=> st_qf);

    // R9
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        err_evt |=> st_err);

endmodule

// File: rtl/doorbell_inbound_queue.sv
module doorbell_inbound_queue
    import dbq_pkg::*;
#(
    parameter int DEPTH_LOG2 = 9
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        db_valid,
    output logic        db_ready,
    input  logic [15:0] db_target,
    input  logic [15:0] db_source,
    input  logic [15:0] db_info,
    input  logic        db_err,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int OFS_W  = DEPTH_LOG2 + REC_BYTES_LOG2;
    localparam int BASE_W = 32 - OFS_W;

    logic              en_q;
    logic [BASE_W-1:0] base_q;
    logic [DEPTH_LOG2-1:0] deq_idx, enq_idx, load_idx;
    logic              empty, full;
    logic              wr_mode, wr_stat, load_deq, load_enq, pop_req;
    logic              accept, push, err_evt;
    logic [7:0]        status;
    dbq_rec_t          in_rec, head_rec;
    dbq_reg_e          ra;

    assign ra       = dbq_reg_e'(reg_addr);
    assign wr_mode  = reg_wr && (ra == RA_MODE);
    assign wr_stat  = reg_wr && (ra == RA_STATUS);
    assign load_deq = reg_wr && (ra == RA_DEQ) && !en_q;
    assign load_enq = reg_wr && (ra == RA_ENQ) && !en_q;
    assign load_idx = reg_wdata[OFS_W-1:REC_BYTES_LOG2];
    assign pop_req  = wr_mode && reg_wdata[MODE_POP_BIT];

    assign db_ready = en_q && !full;
    assign accept   = db_valid && db_ready;
    assign push     = accept && !db_err;
    assign err_evt  = accept && db_err;

    assign in_rec = '{target: db_target, source: db_source, info: db_info};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            base_q <= '0;
        end else begin
            if (wr_mode)  en_q   <= reg_wdata[MODE_EN_BIT];
            if (load_deq) base_q <= reg_wdata[31:OFS_W];
        end
    end

    dbq_ring_ptrs #(.IDX_W(DEPTH_LOG2)) ptrs_i (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop_req  (pop_req),
        .load_deq (load_deq),
        .load_enq (load_enq),
        .load_idx (load_idx),
        .deq_idx  (deq_idx),
        .enq_idx  (enq_idx),
        .empty    (empty),
        .full     (full)
    );

    dbq_rec_ram #(.IDX_W(DEPTH_LOG2)) ram_i (
        .clk    (clk),
        .wr_en  (push),
        .wr_idx (enq_idx),
        .wr_rec (in_rec),
        .rd_idx (deq_idx),
        .rd_rec (head_rec)
    );

    dbq_status stat_i (
        .clk      (clk),
        .rst      (rst),
        .clr_wr   (wr_stat),
        .clr_mask (reg_wdata[7:0]),
        .empty    (empty),
        .full     (full),
        .err_evt  (err_evt),
        .status   (status),
        .irq      (irq)
    );

    always_comb begin
        case (ra)
            RA_MODE:   reg_rdata = {31'd0, en_q};
            RA_STATUS: reg_rdata = {24'd0, status};
            RA_DEQ:    reg_rdata = {base_q, deq_idx, {REC_BYTES_LOG2{1'b0}}};
            RA_ENQ:    reg_rdata = {base_q, enq_idx, {REC_BYTES_LOG2{1'b0}}};
            RA_REC_HI: reg_rdata = rec_word(head_rec, 1'b1);
            RA_REC_LO: reg_rdata = rec_word(head_rec, 1'b0);
            default:   reg_rdata = 32'd0;
        endcase
    end

    // R2
    idle_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_q && db_valid) |=> $stable(enq_idx));

    // R9
    err_no_store_chk: assert property (@(posedge clk) disable iff (rst)
        (err_evt && !load_enq) |=> $stable(enq_idx));

endmodule

// File: tb/doorbell_inbound_queue_tb_top.sv
`timescale 1ns/1ps
module doorbell_inbound_queue_tb_top;
    localparam int DL2 = 3;
    localparam logic [31:0] BASE = 32'h1000_0000;
    localparam logic [2:0] A_MODE = 3'd0, A_STAT = 3'd1, A_DEQ = 3'd2,
                           A_ENQ = 3'd3, A_HI = 3'd4, A_LO = 3'd5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic db_valid = 1'b0, db_err = 1'b0;
    logic [15:0] db_target = '0, db_source = '0, db_info = '0;
    logic [2:0] reg_addr = '0;
    logic reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic db_ready, irq;
    logic [31:0] reg_rdata;

    int n_checks = 0;
    int n_errs = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    doorbell_inbound_queue #(.DEPTH_LOG2(DL2)) dut_i (
        .clk(clk), .rst(rst), .db_valid(db_valid), .db_ready(db_ready),
        .db_target(db_target), .db_source(db_source), .db_info(db_info),
        .db_err(db_err), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errs++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic send(input logic [15:0] t, input logic [15:0] s,
                        input logic [15:0] i, input logic e, output bit taken);
        int waits = 0;
        @(negedge clk);
        db_target = t; db_source = s; db_info = i; db_err = e; db_valid = 1'b1;
        while (!db_ready && waits < 20) begin
            @(negedge clk);
            waits++;
        end
        taken = db_ready;
        @(negedge clk);
        db_valid = 1'b0; db_err = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_MODE, v); check("R1 mode", v, 0);
        rd(A_STAT, v); check("R1 status", v, 0);
        rd(A_DEQ, v);  check("R1 deq", v, 0);
        rd(A_ENQ, v);  check("R1 enq", v, 0);
        check("R1 ready", {31'd0, db_ready}, 0);
        check("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_init();
        logic [31:0] v;
        wr(A_DEQ, BASE);
        wr(A_ENQ, BASE);
        rd(A_DEQ, v); check("R11 deq load", v, BASE);
        rd(A_ENQ, v); check("R11 enq load", v, BASE);
        check("R2 ready while disabled", {31'd0, db_ready}, 0);
        wr(A_MODE, 32'h1);
        check("R2 ready when enabled", {31'd0, db_ready}, 1);
        wr(A_DEQ, BASE + 32'h20);
        rd(A_DEQ, v); check("R11 write ignored when enabled", v, BASE);
    endtask

    task automatic t_store();
        logic [31:0] v; bit tk;
        send(16'h0011, 16'h0022, 16'hA001, 1'b0, tk);
        send(16'h0012, 16'h0023, 16'hA002, 1'b0, tk);
        send(16'h0013, 16'h0024, 16'hA003, 1'b0, tk);
        rd(A_ENQ, v); check("R3 enq advance", v, BASE + 32'h18);
        @(negedge clk);
        rd(A_STAT, v); check("R7 not-empty set", v, 32'h01);
        check("R10 irq from not-empty", {31'd0, irq}, 1);
        rd(A_HI, v); check("R4 upper word", v, 32'h0000_0011);
        rd(A_LO, v); check("R4 lower word", v, 32'h0022_A001);
        wr(A_MODE, 32'h3);
        rd(A_MODE, v); check("R5 pop bit reads 0", v, 32'h1);
        rd(A_DEQ, v);  check("R5 deq advance", v, BASE + 32'h8);
        rd(A_HI, v); check("R4 next upper", v, 32'h0000_0012);
        rd(A_LO, v); check("R4 next lower", v, 32'h0023_A002);
    endtask

    task automatic t_rearm();
        logic [31:0] v;
        wr(A_STAT, 32'h01);
        rd(A_STAT, v); check("R7 cleared", v, 32'h00);
        @(negedge clk);
        rd(A_STAT, v); check("R7 re-set while not empty", v, 32'h01);
        wr(A_MODE, 32'h3);
        wr(A_MODE, 32'h3);
        rd(A_DEQ, v); check("R5 drained", v, BASE + 32'h18);
        wr(A_STAT, 32'h01);
        @(negedge clk); @(negedge clk);
        rd(A_STAT, v); check("R7 stays clear when empty", v, 32'h00);
        check("R10 irq low", {31'd0, irq}, 0);
    endtask

    task automatic t_empty_pop();
        logic [31:0] v;
        wr(A_MODE, 32'h3);
        rd(A_DEQ, v); check("R6 empty pop ignored", v, BASE + 32'h18);
        rd(A_ENQ, v); check("R6 enq untouched", v, BASE + 32'h18);
    endtask

    task automatic t_full();
        logic [31:0] v; bit tk;
        for (int i = 0; i < 8; i++) begin
            send(16'h0040 + 16'(i), 16'h0050 + 16'(i), 16'hB000 + 16'(i), 1'b0, tk);
            check("R3 accepted", {31'd0, tk}, 1);
        end
        rd(A_ENQ, v); check("R3 enq wrap", v, BASE + 32'h18);
        check("R8 ready low when full", {31'd0, db_ready}, 0);
        @(negedge clk);
        rd(A_STAT, v); check("R8 full flag", v, 32'h11);
        db_target = 16'hDEAD; db_source = 16'hBEEF; db_info = 16'hCAFE; db_valid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 ready held low", {31'd0, db_ready}, 0);
        end
        db_valid = 1'b0;
        rd(A_ENQ, v); check("R8 enq held", v, BASE + 32'h18);
        rd(A_HI, v); check("R8 oldest intact hi", v, 32'h0000_0040);
        rd(A_LO, v); check("R8 oldest intact lo", v, 32'h0050_B000);
        wr(A_MODE, 32'h3);
        check("R2 ready back after pop", {31'd0, db_ready}, 1);
        for (int k = 0; k < 6; k++) wr(A_MODE, 32'h3);
        rd(A_LO, v); check("R4 last record", v, 32'h0057_B007);
        wr(A_MODE, 32'h3);
        rd(A_DEQ, v); check("R5 deq wrap", v, BASE + 32'h18);
        wr(A_STAT, 32'h11);
        @(negedge clk); @(negedge clk);
        rd(A_STAT, v); check("R8 flag clears when not full", v, 32'h00);
    endtask

    task automatic t_error();
        logic [31:0] v; bit tk;
        send(16'h0001, 16'h0002, 16'h0003, 1'b1, tk);
        check("R9 error event consumed", {31'd0, tk}, 1);
        rd(A_ENQ, v); check("R9 not stored", v, BASE + 32'h18);
        @(negedge clk);
        rd(A_STAT, v); check("R9 error flag", v, 32'h80);
        check("R10 irq from error", {31'd0, irq}, 1);
        send(16'h0004, 16'h0005, 16'h0006, 1'b0, tk);
        @(negedge clk);
        rd(A_STAT, v); check("R10 two flags", v, 32'h81);
        wr(A_MODE, 32'h3);
        wr(A_STAT, 32'h91);
        @(negedge clk);
        rd(A_STAT, v); check("R10 all cleared", v, 32'h00);
        check("R10 irq low after clear", {31'd0, irq}, 0);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        wr(A_MODE, 32'h0);
        check("R2 ready low when disabled", {31'd0, db_ready}, 0);
        db_valid = 1'b1;
        @(negedge clk); @(negedge clk);
        db_valid = 1'b0;
        rd(A_ENQ, v); check("R2 nothing taken", v, BASE + 32'h20);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_init();
        t_store();
        t_rearm();
        t_empty_pop();
        t_full();
        t_error();
        t_disable();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errs++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end

endmodule